// File: doc/BRIEF.md
# Multichannel Serial-to-Parallel Converter with Per-Channel Bit Slip

This block turns several serial bit streams into parallel words, each of `WORD_W` bits. The whole block runs on one fast clock. A bit-enable strobe marks the cycles that carry a new serial bit on every lane. Each lane gathers its bits most-significant-first. Once a word is complete, the lane presents it on its slice of the wide parallel bus, together with a one-cycle word strobe. That strobe serves as the parallel clock for whatever logic reads the bus.

Word alignment is adjusted one lane at a time. A rising edge on a lane's align input asks that lane to push its word boundary one serial bit later. The lane does this by holding back its next word strobe by one bit. The other lanes keep their timing. A shared rollover setting chooses how many slips make a full cycle. The slip that completes the cycle raises the lane's rollover flag for one word period. The next slip request after that restores the lane's original bit phase. Each lane also has its own asynchronous realignment reset, which clears all of its slip bookkeeping.

Top module: `sdes_bitslip_rx`

## Requirements
- R1: Lane c fills `par_out[c*WORD_W +: WORD_W]`. Its bits arrive most-significant-first, so the earliest bit of a word is at bit `WORD_W-1` of the slice, and the latest is at bit 0.
- R2: After `rst_n` is released, the first word of every lane is strobed by `word_vld` in the cycle after the clock edge that takes the `WORD_W`-th enabled bit. With no slips, later words follow every `WORD_W` enabled bits. `word_vld` is a single-cycle pulse.
- R3: While `bit_en` is low, no lane shifts, strobes or changes its output.
- R4: A lane's slice of `par_out` changes only in a cycle where that lane's `word_vld` is high.
- R5: A rising edge on `align[c]` is registered. It delays lane c's next word boundary by exactly one enabled bit. That word holds the latest `WORD_W` bits. The other lanes are unaffected.
- R6: A rising edge on `align[c]` that arrives while lane c still has a slip waiting is ignored. A level held high makes no second request.
- R7: The slip that brings lane c's slip count to the effective rollover value R sets `roll_flag[c]`. The flag rises with the next `word_vld[c]` and falls with the one after.
- R8: The first slip that lane c performs after its count has reached R holds the boundary `(WORD_W - R) mod WORD_W` bits instead of one. This returns the lane to the bit phase it had with zero slips, and its count restarts at zero.
- R9: A `roll_cnt` value of 0, or any value above `WORD_W`, acts as `WORD_W`.
- R10: While `realign_rst_n[c]` is low, lane c's slip count, waiting request and rollover flag are held cleared. Its word timing and data path keep running.
- R11: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset of the whole block; release synchronously |
| bit_en | input | 1 | High in cycles that carry a new serial bit on every lane |
| ser_in | input | NUM_CH | One serial bit per lane |
| align | input | NUM_CH | Per-lane slip request; rising edge counts |
| realign_rst_n | input | NUM_CH | Per-lane asynchronous active-low reset of slip state |
| roll_cnt | input | $clog2(WORD_W+1) | Slips per rollover cycle, 1..WORD_W |
| par_out | output | NUM_CH*WORD_W | Parallel words, lane 0 in the low slice |
| word_vld | output | NUM_CH | Per-lane one-cycle word strobe |
| roll_flag | output | NUM_CH | Per-lane rollover flag, high for one word period |

## Verification
The lanes are fed bit streams that differ from lane to lane and are not periodic, so a wrong word boundary or a swapped lane changes the captured value. The sweep covers six rollover settings: 1 through 4 and the two clamped codes 0 and 7. Under each setting, every lane gets repeated slip requests at staggered times, well past the rollover point. This separates one-bit holds from restore holds and shows whether a lane's slips leak into its neighbours. The enable pattern runs continuously in one phase and gapped in the others, which exposes any shift or strobe on a disabled cycle. One phase adds extra request edges while a slip is still waiting, and another holds one lane in realignment reset partway through, to show that the ignored edges and the cleared state leave the word timing unchanged.

// File: rtl/sdes_pkg.sv
package sdes_pkg;

  // Effective slips per rollover: out-of-range requests fall back to the word width.
  function automatic int eff_roll(input int req, input int depth);
    return (req < 1 || req > depth) ? depth : req;
  endfunction

  // Extra hold that returns a lane to its zero-slip bit phase.
  function automatic int restore_hold(input int slips, input int depth);
    return (depth - slips) % depth;
  endfunction

endpackage

// File: rtl/sdes_shift_lane.sv
module sdes_shift_lane #(
  parameter int WORD_W = 4,
  parameter int HOLD_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              ser_bit,
  input  logic              slip_take,
  input  logic [HOLD_W-1:0] slip_hold,
  output logic              at_bound,
  output logic              emit_now,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);

  localparam logic [HOLD_W-1:0] LAST = HOLD_W'(WORD_W - 1);

  logic [HOLD_W-1:0] cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              vld_q, vld_d;
  logic              hold_now;

  always_comb begin
    at_bound = bit_en && (cnt_q == LAST);
    hold_now = slip_take && (slip_hold != '0);
    emit_now = at_bound && !hold_now;
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    if (bit_en) begin
      sh_d = {sh_q[WORD_W-2:0], ser_bit};
      if (at_bound) begin
        cnt_d = hold_now ? HOLD_W'(WORD_W - int'(slip_hold)) : '0;
      end else begin
        cnt_d = cnt_q + HOLD_W'(1);
      end
    end
    word_d = emit_now ? sh_d : word_q;
    vld_d  = emit_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      word_q <= word_d;
      vld_q  <= vld_d;
    end
  end

  assign word     = word_q;
  assign word_vld = vld_q;

endmodule

// File: rtl/sdes_slip_ctrl.sv
module sdes_slip_ctrl
  import sdes_pkg::*;
#(
  parameter int WORD_W = 4,
  parameter int HOLD_W = $clog2(WORD_W),
  parameter int ROLL_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              align,
  input  logic [ROLL_W-1:0] roll_req,
  input  logic              at_bound,
  input  logic              emit_now,
  output logic              slip_take,
  output logic [HOLD_W-1:0] slip_hold,
  output logic              roll_flag
);

  logic              align_q;
  logic              pend_q, pend_d;
  logic [ROLL_W-1:0] scnt_q, scnt_d;
  logic              rnew_q, rnew_d;
  logic              flag_q, flag_d;
  logic              restore;
  logic              rise;
  int                r_eff;

  always_comb begin
    r_eff     = eff_roll(int'(roll_req), WORD_W);
    restore   = int'(scnt_q) >= r_eff;
    slip_take = at_bound && pend_q;
    slip_hold = restore ? HOLD_W'(restore_hold(int'(scnt_q), WORD_W)) : HOLD_W'(1);
    rise      = align && !align_q;

    pend_d = slip_take ? 1'b0 : (rise ? 1'b1 : pend_q);

    rnew_d = emit_now ? 1'b0 : rnew_q;
    flag_d = emit_now ? rnew_q : flag_q;
    scnt_d = scnt_q;
    if (slip_take) begin
      if (restore) begin
        scnt_d = '0;
      end else begin
        scnt_d = scnt_q + ROLL_W'(1);
        if (int'(scnt_q) + 1 == r_eff) rnew_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      align_q <= 1'b0;
      pend_q  <= 1'b0;
      scnt_q  <= '0;
      rnew_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      align_q <= align;
      pend_q  <= pend_d;
      scnt_q  <= scnt_d;
      rnew_q  <= rnew_d;
      flag_q  <= flag_d;
    end
  end

  assign roll_flag = flag_q;

endmodule

// File: rtl/sdes_bitslip_rx.sv
module sdes_bitslip_rx #(
  parameter int NUM_CH = 3,
  parameter int WORD_W = 4,
  parameter int ROLL_W = $clog2(WORD_W + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bit_en,
  input  logic [NUM_CH-1:0]        ser_in,
  input  logic [NUM_CH-1:0]        align,
  input  logic [NUM_CH-1:0]        realign_rst_n,
  input  logic [ROLL_W-1:0]        roll_cnt,
  output logic [NUM_CH*WORD_W-1:0] par_out,
  output logic [NUM_CH-1:0]        word_vld,
  output logic [NUM_CH-1:0]        roll_flag
);

  localparam int HOLD_W = $clog2(WORD_W);

  logic [NUM_CH-1:0] ch_rst_n;
  logic [NUM_CH-1:0] at_bound;
  logic [NUM_CH-1:0] emit_now;
  logic [NUM_CH-1:0] slip_take;
  logic [HOLD_W-1:0] slip_hold [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_rst_n[i] = rst_n & realign_rst_n[i];

    sdes_shift_lane #(
      .WORD_W (WORD_W),
      .HOLD_W (HOLD_W)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .ser_bit   (ser_in[i]),
      .slip_take (slip_take[i]),
      .slip_hold (slip_hold[i]),
      .at_bound  (at_bound[i]),
      .emit_now  (emit_now[i]),
      .word_vld  (word_vld[i]),
      .word      (par_out[i*WORD_W +: WORD_W])
    );

    sdes_slip_ctrl #(
      .WORD_W (WORD_W),
      .HOLD_W (HOLD_W),
      .ROLL_W (ROLL_W)
    ) u_slip (
      .clk       (clk),
      .arst_n    (ch_rst_n[i]),
      .align     (align[i]),
      .roll_req  (roll_cnt),
      .at_bound  (at_bound[i]),
      .emit_now  (emit_now[i]),
      .slip_take (slip_take[i]),
      .slip_hold (slip_hold[i]),
      .roll_flag (roll_flag[i])
    );
  end

endmodule

// File: rtl/sdes_bitslip_rx_chk.sv
module sdes_bitslip_rx_chk #(
  parameter int NUM_CH = 3,
  parameter int WORD_W = 4,
  parameter int ROLL_W = $clog2(WORD_W + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bit_en,
  input logic [NUM_CH-1:0]        realign_rst_n,
  input logic [NUM_CH*WORD_W-1:0] par_out,
  input logic [NUM_CH-1:0]        word_vld,
  input logic [NUM_CH-1:0]        roll_flag
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R4: a slice moves only together with its strobe
    a_r4_par_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld[i] |-> $stable(par_out[i*WORD_W +: WORD_W]));

    // R3: a strobe always follows an enabled bit
    a_r3_vld_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld[i] |-> $past(bit_en));

    // R2: the strobe lasts one cycle
    a_r2_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld[i] |=> !word_vld[i]);

    // R7: the flag rises only with a word strobe
    a_r7_flag_rise: assert property (@(posedge clk) disable iff (!rst_n || !realign_rst_n[i])
      $rose(roll_flag[i]) |-> word_vld[i]);

    // R7: the flag falls only with a word strobe
    a_r7_flag_fall: assert property (@(posedge clk) disable iff (!rst_n || !realign_rst_n[i])
      $fell(roll_flag[i]) |-> word_vld[i]);

    // R10: the realignment reset holds the flag low
    a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !realign_rst_n[i] |-> !roll_flag[i]);
  end

endmodule

bind sdes_bitslip_rx sdes_bitslip_rx_chk #(
  .NUM_CH (NUM_CH),
  .WORD_W (WORD_W),
  .ROLL_W (ROLL_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bit_en        (bit_en),
  .realign_rst_n (realign_rst_n),
  .par_out       (par_out),
  .word_vld      (word_vld),
  .roll_flag     (roll_flag)
);

// File: tb/sdes_bitslip_rx_tb.sv
module sdes_bitslip_rx_tb;

  localparam int N      = 3;
  localparam int J      = 4;
  localparam int RW     = $clog2(J + 1);
  localparam int PERIOD = 10;

  logic             clk;
  logic             rst_n;
  logic             bit_en;
  logic [N-1:0]     ser_in;
  logic [N-1:0]     align;
  logic [N-1:0]     realign_rst_n;
  logic [RW-1:0]    roll_cnt;
  logic [N*J-1:0]   par_out;
  logic [N-1:0]     word_vld;
  logic [N-1:0]     roll_flag;

  sdes_bitslip_rx #(.NUM_CH(N), .WORD_W(J)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_en        (bit_en),
    .ser_in        (ser_in),
    .align         (align),
    .realign_rst_n (realign_rst_n),
    .roll_cnt      (roll_cnt),
    .par_out       (par_out),
    .word_vld      (word_vld),
    .roll_flag     (roll_flag)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  int           bitidx;
  bit           hist [N][2048];
  int           sc [N];
  int           exp_next [N];
  bit           pend [N];
  bit           rn [N];
  bit           fl [N];
  bit           alq [N];
  logic [J-1:0] exp_w [N];

  function automatic bit pat(input int c, input int k);
    return 1'(((k * k + 3 * c * k + c + (k >> 3)) >> 1) & 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic tick(input bit be, input logic [N-1:0] al, input logic [N-1:0] rr);
    @(negedge clk);
    bit_en = be;
    if (be) begin
      bitidx++;
      for (int c = 0; c < N; c++) begin
        hist[c][bitidx] = pat(c, bitidx);
        ser_in[c]       = pat(c, bitidx);
      end
    end
    align         = al;
    realign_rst_n = rr;
    @(posedge clk);
    #1;
    for (int c = 0; c < N; c++) begin
      int  rv;
      bit  bnd, take, emit, rise, rnset;
      int  h;
      rv    = (int'(roll_cnt) < 1 || int'(roll_cnt) > J) ? J : int'(roll_cnt);  // R9
      bnd   = be && (bitidx == exp_next[c]);
      emit  = bnd;
      rnset = 0;
      if (!rr[c]) begin
        sc[c] = 0; pend[c] = 0; rn[c] = 0; fl[c] = 0; alq[c] = 0;       // R10
        if (emit) exp_next[c] += J;
      end else begin
        rise   = al[c] && !alq[c];
        alq[c] = al[c];
        take   = bnd && pend[c];
        if (take) begin
          if (sc[c] >= rv) begin                                          // R8
            h = (J - sc[c]) % J;
            sc[c] = 0;
          end else begin                                                  // R5, R7
            h = 1;
            sc[c]++;
            if (sc[c] == rv) rnset = 1;
          end
          if (h > 0) begin
            emit = 0;
            exp_next[c] = bitidx + h;
          end
        end
        pend[c] = take ? 1'b0 : ((rise && !pend[c]) ? 1'b1 : pend[c]);   // R6
        if (emit) begin
          fl[c] = rn[c];
          rn[c] = 0;
          exp_next[c] = bitidx + J;
        end
        if (rnset) rn[c] = 1;
      end
      if (be)
        chk(word_vld[c] == emit, "R2/R5/R6/R8/R9 word strobe timing", int'(word_vld[c]), int'(emit));
      else
        chk(word_vld[c] == 1'b0, "R3 no strobe without bit enable", int'(word_vld[c]), 0);
      if (emit) begin
        for (int k = 0; k < J; k++) exp_w[c][J-1-k] = hist[c][bitidx-J+1+k];
        chk(par_out[c*J +: J] == exp_w[c], "R1/R5 word content", int'(par_out[c*J +: J]), int'(exp_w[c]));
      end else begin
        chk(par_out[c*J +: J] == exp_w[c], "R4 data held between strobes", int'(par_out[c*J +: J]), int'(exp_w[c]));
      end
      chk(roll_flag[c] == fl[c], rr[c] ? "R7/R8 rollover flag" : "R10 flag cleared by realign reset",
          int'(roll_flag[c]), int'(fl[c]));
    end
  endtask

  initial begin
    int rolls [6] = '{2, 4, 0, 1, 3, 7};
    rst_n         = 1'b0;
    bit_en        = 1'b0;
    ser_in        = '0;
    align         = '0;
    realign_rst_n = '1;
    roll_cnt      = RW'(2);
    bitidx        = 0;
    for (int c = 0; c < N; c++) begin
      sc[c] = 0; exp_next[c] = J; pend[c] = 0; rn[c] = 0; fl[c] = 0; alq[c] = 0; exp_w[c] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk(par_out == '0, "R11 data zero in reset", int'(par_out), 0);
    chk(word_vld == '0, "R11 strobe low in reset", int'(word_vld), 0);
    chk(roll_flag == '0, "R11 flag low in reset", int'(roll_flag), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int p = 0; p < 6; p++) begin
      roll_cnt = RW'(rolls[p]);
      for (int cy = 0; cy < 150; cy++) begin
        logic [N-1:0] al;
        logic [N-1:0] rr;
        bit           be;
        be = (p == 0) ? 1'b1 : ((cy % 5) != 2);
        for (int c = 0; c < N; c++) begin
          int ph;
          ph    = (cy + 6 * c) % 16;
          al[c] = (ph < 2) || (p == 3 && ph == 3);
        end
        rr = '1;
        if (p == 4 && cy >= 60 && cy < 76) rr[1] = 1'b0;
        tick(be, al, rr);
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule